// File: doc/BRIEF.md
# Parallel Instruction Boundary Decoder

This block takes a 16-byte fetch block, viewed as eight 16-bit parcels, and finds every instruction start in it in a single clock. Every instruction is one to four parcels long. Its first parcel states the length, so no byte-serial scan and no prefix handling are needed. For each parcel the block reports whether an instruction starts there. It also decodes the fields of every starting parcel: length code, opcode, two register specifiers and a bit that stops the instruction from updating the flags.

An instruction can run past the last parcel of a block. When it does, the block remembers how many parcels are still owed and treats that many leading parcels of the next accepted block as continuation. A flush input clears this carried state.

Both the fetch side and the queue side use valid/ready. A block is taken on a clock edge where `in_valid` and `in_ready` are both high. The decoded result appears on the next cycle and stays on the outputs, unchanged, until a cycle where `out_valid` and `out_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. A full queue therefore stops intake at once and freezes all decoder state.

Top module: `parcel_boundary_decoder`

## Requirements
- R1: While reset (`rst_n` low) is applied, and after it is released, `out_valid` is 0 and `in_ready` is 1 until a block is accepted.
- R2: Each starting parcel is decoded as [15:14] length code (0..3 means 1..4 parcels), [13] no-flags, [12:8] opcode, [7:4] first register, [3:0] second register. `out_len` slot i holds the code of parcel i.
- R3: With no continuation pending, parcel 0 is a start. A start whose length code is k is followed by k non-start parcels, and the parcel after those is again a start.
- R4: If the last instruction of a block needs n more parcels (1..3), the first n parcels of the next accepted block are not starts, and decoding resumes at parcel n.
- R5: `out_valid` rises on the cycle after a block is accepted. It stays high until the result is taken, and it is high only while an accepted result is waiting.
- R6: `in_ready` equals (not `out_valid`) or `out_ready`. While `out_valid` is high and `out_ready` is low, every output holds its value.
- R7: While `flush` is high, pending continuation is dropped. A block accepted in a flush cycle, or after one, is decoded from parcel 0.
- R8: For a slot whose start bit is 0, the no-flags, opcode and register outputs are 0. For a start slot they come from that slot's parcel.
- R9: With `out_ready` held high, a new block is accepted on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Drop pending continuation state |
| in_valid | input | 1 | Fetch block offered |
| in_ready | output | 1 | Decoder can take a block this cycle |
| in_block | input | 128 | Fetch block; parcel i is bits [16i+15:16i] |
| out_valid | output | 1 | Decoded result present |
| out_ready | input | 1 | Queue can take the result |
| out_start | output | 8 | Bit i set when an instruction starts at parcel i |
| out_len | output | 16 | Per-slot 2-bit length code |
| out_noflag | output | 8 | Per-slot no-flags bit |
| out_opc | output | 40 | Per-slot 5-bit opcode |
| out_reg1 | output | 32 | Per-slot first register |
| out_reg2 | output | 32 | Per-slot second register |

## Verification
A wrong carried continuation count first shows in the start mask of the next accepted block. The leading parcels come out as starts when they should be skipped, or the reverse. From that point every later boundary in the block is shifted, until a block ends cleanly or a flush clears the count. A mistake in the output register's valid or hold logic shows within one cycle, either as `out_valid` disagreeing with the count of pending results or as fields changing under back-pressure. The reference model in the bench walks each block parcel by parcel and is compared on every cycle, so both kinds of fault surface in the cycle they occur.

// File: rtl/pbd_pkg.sv
package pbd_pkg;
  localparam int PW      = 16;
  localparam int LEN_W   = 2;
  localparam int OPC_W   = 5;
  localparam int REG_W   = 4;
  localparam int CARRY_W = LEN_W;

  typedef struct packed {
    logic [LEN_W-1:0] len;
    logic             noflag;
    logic [OPC_W-1:0] opc;
    logic [REG_W-1:0] ra;
    logic [REG_W-1:0] rb;
  } parcel_t;
endpackage

// File: rtl/pbd_boundary_scan.sv
module pbd_boundary_scan
  import pbd_pkg::*;
#(
  parameter int NP = 8
) (
  input  logic [NP*PW-1:0]   blk,
  input  logic [CARRY_W-1:0] carry_in,
  output logic [NP-1:0]      start,
  output logic [CARRY_W-1:0] carry_out
);
  logic [NP*LEN_W-1:0] codes;

  for (genvar g = 0; g < NP; g++) begin : g_code
    parcel_t p;
    assign p = parcel_t'(blk[g*PW +: PW]);
    assign codes[g*LEN_W +: LEN_W] = p.len;
  end

  // skip counts parcels still owned by an earlier instruction
  always_comb begin
    logic [CARRY_W-1:0] skip;
    skip  = carry_in;
    start = '0;
    for (int i = 0; i < NP; i++) begin
      if (skip == '0) begin
        start[i] = 1'b1;
        skip     = codes[i*LEN_W +: LEN_W];
      end else begin
        skip = skip - 1'b1;
      end
    end
    carry_out = skip;
  end
endmodule

// File: rtl/pbd_slot_extract.sv
module pbd_slot_extract
  import pbd_pkg::*;
#(
  parameter int NP = 8
) (
  input  logic [NP*PW-1:0]    blk,
  input  logic [NP-1:0]       start,
  output logic [NP*LEN_W-1:0] len,
  output logic [NP-1:0]       noflag,
  output logic [NP*OPC_W-1:0] opc,
  output logic [NP*REG_W-1:0] ra,
  output logic [NP*REG_W-1:0] rb
);
  for (genvar g = 0; g < NP; g++) begin : g_slot
    parcel_t p;
    assign p = start[g] ? parcel_t'(blk[g*PW +: PW]) : '0;
    assign len[g*LEN_W +: LEN_W] = p.len;
    assign noflag[g]             = p.noflag;
    assign opc[g*OPC_W +: OPC_W] = p.opc;
    assign ra[g*REG_W +: REG_W]  = p.ra;
    assign rb[g*REG_W +: REG_W]  = p.rb;
  end
endmodule

// File: rtl/parcel_boundary_decoder.sv
module parcel_boundary_decoder
  import pbd_pkg::*;
#(
  parameter int NP = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [NP*PW-1:0]    in_block,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [NP-1:0]       out_start,
  output logic [NP*LEN_W-1:0] out_len,
  output logic [NP-1:0]       out_noflag,
  output logic [NP*OPC_W-1:0] out_opc,
  output logic [NP*REG_W-1:0] out_reg1,
  output logic [NP*REG_W-1:0] out_reg2
);
  logic [CARRY_W-1:0] carry_q, carry_eff, carry_nx;
  logic [NP-1:0]       start_c, noflag_c;
  logic [NP*LEN_W-1:0] len_c;
  logic [NP*OPC_W-1:0] opc_c;
  logic [NP*REG_W-1:0] ra_c, rb_c;
  logic                accept;

  assign in_ready  = !out_valid || out_ready;
  assign accept    = in_valid && in_ready;
  assign carry_eff = flush ? '0 : carry_q;

  pbd_boundary_scan #(.NP(NP)) u_scan (
    .blk(in_block), .carry_in(carry_eff), .start(start_c), .carry_out(carry_nx)
  );

  pbd_slot_extract #(.NP(NP)) u_fields (
    .blk(in_block), .start(start_c), .len(len_c), .noflag(noflag_c),
    .opc(opc_c), .ra(ra_c), .rb(rb_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_q    <= '0;
      out_valid  <= 1'b0;
      out_start  <= '0;
      out_len    <= '0;
      out_noflag <= '0;
      out_opc    <= '0;
      out_reg1   <= '0;
      out_reg2   <= '0;
    end else if (accept) begin
      carry_q    <= carry_nx;
      out_valid  <= 1'b1;
      out_start  <= start_c;
      out_len    <= len_c;
      out_noflag <= noflag_c;
      out_opc    <= opc_c;
      out_reg1   <= ra_c;
      out_reg2   <= rb_c;
    end else begin
      if (out_ready) out_valid <= 1'b0;
      if (flush) carry_q <= '0;
    end
  end
endmodule

// File: rtl/pbd_checker.sv
module pbd_checker
  import pbd_pkg::*;
#(
  parameter int NP = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic                out_valid,
  input logic                out_ready,
  input logic [NP-1:0]       out_start,
  input logic [NP*LEN_W-1:0] out_len,
  input logic [NP-1:0]       out_noflag,
  input logic [NP*OPC_W-1:0] out_opc
);
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_start) &&
      $stable(out_len) && $stable(out_opc) && $stable(out_noflag)));

  assert_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> (out_valid && !out_ready));

  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_noflag & ~out_start) == '0));

  assert_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));
endmodule

bind parcel_boundary_decoder pbd_checker #(.NP(NP)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_start(out_start),
  .out_len(out_len), .out_noflag(out_noflag), .out_opc(out_opc)
);

// File: tb/parcel_boundary_decoder_test.sv
module parcel_boundary_decoder_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n, flush, in_valid, in_ready, out_valid, out_ready;
  logic [127:0] in_block;
  logic [7:0]   out_start, out_noflag;
  logic [15:0]  out_len;
  logic [39:0]  out_opc;
  logic [31:0]  out_reg1, out_reg2;

  parcel_boundary_decoder uut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
    .in_ready(in_ready), .in_block(in_block), .out_valid(out_valid),
    .out_ready(out_ready), .out_start(out_start), .out_len(out_len),
    .out_noflag(out_noflag), .out_opc(out_opc), .out_reg1(out_reg1),
    .out_reg2(out_reg2)
  );

  typedef struct {
    logic [7:0]  st;
    logic [15:0] ln;
    logic [7:0]  nf;
    logic [39:0] op;
    logic [31:0] a;
    logic [31:0] b;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   errors = 0, checks = 0, carry = 0;
  bit   active = 0, stream = 0, done = 0;

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // reference: walk the parcels one at a time, owing parcels across blocks
  task automatic predict(input logic [127:0] d, input bit fl);
    exp_t e;
    int   owe;
    owe   = fl ? 0 : carry;
    e.tag = fl ? "R7" : (owe > 0 ? "R4" : "R3");
    e.st = '0; e.ln = '0; e.nf = '0; e.op = '0; e.a = '0; e.b = '0;
    for (int p = 0; p < 8; p++) begin
      logic [15:0] w;
      w = d[p*16 +: 16];
      if (owe == 0) begin
        e.st[p]        = 1'b1;
        e.ln[p*2 +: 2] = w[15:14];
        e.nf[p]        = w[13];
        e.op[p*5 +: 5] = w[12:8];
        e.a[p*4 +: 4]  = w[7:4];
        e.b[p*4 +: 4]  = w[3:0];
        owe            = int'(w[15:14]);
      end else begin
        owe--;
      end
    end
    carry = owe;
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (active && !done) begin
      check(out_valid == (q.size() != 0), "R5", 64'(out_valid), 64'(q.size() != 0));
      check(in_ready == (!out_valid || out_ready), "R6", 64'(in_ready),
            64'(!out_valid || out_ready));
      if (stream) check(in_ready, "R9", 64'(in_ready), 64'd1);
      if (out_valid && out_ready && q.size() != 0) begin
        exp_t e;
        e = q.pop_front();
        check(out_start == e.st, e.tag, 64'(out_start), 64'(e.st));
        check(out_len == e.ln, "R2", 64'(out_len), 64'(e.ln));
        check(out_noflag == e.nf, "R8", 64'(out_noflag), 64'(e.nf));
        check(out_opc == e.op, "R8", 64'(out_opc), 64'(e.op));
        check(out_reg1 == e.a, "R8", 64'(out_reg1), 64'(e.a));
        check(out_reg2 == e.b, "R8", 64'(out_reg2), 64'(e.b));
      end
      if (in_valid && in_ready) predict(in_block, flush);
      else if (flush) carry = 0;
    end
  end

  function automatic logic [127:0] rnd_block();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic send(input logic [127:0] d, input bit fl);
    bit hs;
    in_valid = 1; in_block = d; flush = fl;
    do begin
      @(negedge clk);
      hs = in_valid && in_ready;
    end while (!hs);
    @(posedge clk); #2;
    in_valid = 0; flush = 0;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    bit hs;
    rst_n = 0; flush = 0; in_valid = 0; out_ready = 0; in_block = '0;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", 64'(out_valid), 64'd0);
    check(in_ready == 1'b1, "R1", 64'(in_ready), 64'd1);
    @(posedge clk); #2;
    rst_n = 1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", 64'(out_valid), 64'd0);
    active = 1;
    @(posedge clk); #2;
    out_ready = 1;
    send('0, 0);                    // eight one-parcel instructions
    send({8{16'hA5C3}}, 0);         // three-parcel: starts 0,3,6, owe 1
    send({8{16'h3F21}}, 0);         // parcel 0 is continuation (R4)
    send({8{16'hC000}}, 0);         // four-parcel: owe 0
    send({8{16'h8000}}, 0);         // owe 1 again
    send({8{16'h1234}}, 1);         // flush with the block: decode from 0 (R7)
    send({8{16'hC0FF}}, 0);
    send({8{16'h4000}}, 0);
    // flush alone while idle
    send({8{16'h8000}}, 0);
    flush = 1; @(posedge clk); #2; flush = 0;
    send({8{16'h2ABC}}, 0);
    // full-rate streaming
    in_valid = 1; in_block = rnd_block(); stream = 1;
    repeat (200) begin
      @(posedge clk); #2;
      in_block = rnd_block();
    end
    stream = 0; in_valid = 0;
    // random traffic with back-pressure and flushes
    for (int c = 0; c < 3000; c++) begin
      @(negedge clk);
      hs = in_valid && in_ready;
      @(posedge clk); #2;
      out_ready = ($urandom % 10) < 6;
      flush = ($urandom % 20) == 0;
      if (!in_valid || hs) begin
        in_valid = ($urandom % 4) != 0;
        in_block = rnd_block();
      end
    end
    in_valid = 0; flush = 0; out_ready = 1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(q.size() == 0 && !out_valid, "R5", 64'(q.size()), 64'd0);
    finish_run();
  end
endmodule